// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz tick strobe into a periodic interrupt event whose rate software selects with a 4-bit code. It keeps a free-running 15-bit count of ticks. While it is enabled, it fires whenever the low bits of that count roll over to zero. Each event is therefore aligned to a multiple of the period on the running count, not to the moment the block was programmed. On each event it emits a one-cycle flag-set pulse. During that pulse it also presents the mask 0xC0, which the surrounding register file ORs into its interrupt status byte, and which also serves as the interrupt request.

The rate code and the enable are captured on a reprogram strobe, which the register file raises whenever software writes either control register. A tick that arrives in the same cycle as the strobe is already judged against the new settings. Codes 1 and 2 are treated as codes 8 and 9, and code 0 switches the generator off.

The controller is a three-state machine:
- `ST_OFF`: disabled.
- `ST_WAIT`: armed, waiting for a boundary.
- `ST_FIRE`: one cycle, pulse out.

From any state, a boundary tick while enabled goes to `ST_FIRE`. Otherwise an enabled configuration goes to `ST_WAIT` and a disabled one to `ST_OFF`. `ST_FIRE` always leaves after one cycle unless a further boundary tick arrives.

Top module: `per_irq_gen`

## Requirements
- R1: After reset, `flag_set` is 0, `flag_mask` is 0x00, the tick count is 0, and the stored configuration is disabled.
- R2: With rate code 0 stored, no event is produced regardless of `pie_en`.
- R3: With `pie_en` stored as 0, no event is produced for any rate code.
- R4: For stored codes 3 to 15 the period is 2^(code-1) ticks, so code 3 gives one event every 4 ticks and code 15 gives one every 16384 ticks.
- R5: Code 1 behaves as code 8 (period 128 ticks) and code 2 behaves as code 9 (period 256 ticks).
- R6: An event occurs on the tick that brings the free-running 15-bit count (counted from reset and wrapping from 32767 to 0) to a multiple of the period. This alignment is independent of when the block was programmed.
- R7: An event shows as `flag_set` high for exactly one cycle, in the cycle after the clock edge that takes the tick. `flag_mask` is 0xC0 in that cycle and 0x00 in every other cycle.
- R8: When `reprog` and a tick fall in the same cycle, the newly presented code and enable decide whether that tick produces an event.
- R9: Changes on `rate_code` or `pie_en` without `reprog` have no effect on the event pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz tick |
| rate_code | input | 4 | Rate select code, sampled on `reprog` |
| pie_en | input | 1 | Periodic enable, sampled on `reprog` |
| reprog | input | 1 | Strobe: either control register was written |
| flag_set | output | 1 | One-cycle event pulse |
| flag_mask | output | 8 | Status bits to OR in: 0xC0 during the pulse, else 0x00 |

## Verification
A reprogram strobe and a tick that crosses a period boundary can arrive in the same cycle. The new settings must then decide the outcome of that tick.

The bench provokes this collision in both directions:
- It idles the generator while disabled until the next tick lands on a multiple of 4. It then enables code 3 in the very cycle of that tick, which must produce a pulse.
- Later, with the generator running, it disables it on a boundary tick, which must produce none.

The scoreboard predicts every cycle's expected pulse from its own tick count, so it judges both outcomes.

// File: rtl/pig_pkg.sv
package pig_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } pig_state_e;

    // Short codes are remapped upward by this amount (1 -> 8, 2 -> 9).
    localparam int unsigned ALIAS_ADD = 7;
    // Highest code that is remapped.
    localparam int unsigned ALIAS_MAX = 2;

endpackage

// File: rtl/pig_tick_counter.sv
module pig_tick_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next
);

    assign cnt_next = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt_next;
        end
    end

endmodule

// File: rtl/pig_rate_decode.sv
module pig_rate_decode
    import pig_pkg::*;
#(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned CNT_W  = 15
) (
    input  logic [CODE_W-1:0] code,
    output logic              code_on,
    output logic [CNT_W-1:0]  low_mask
);

    localparam int unsigned K_W = CODE_W + 1;

    logic [K_W-1:0] k_val;
    logic [31:0]    shift_amt;

    assign code_on = (code != '0);

    always_comb begin
        if (code_on && (32'(code) <= ALIAS_MAX)) begin
            k_val = {1'b0, code} + K_W'(ALIAS_ADD);
        end else begin
            k_val = {1'b0, code};
        end
        shift_amt = code_on ? (32'(k_val) - 32'd1) : 32'd0;
    end

    // Bit g of the mask is set when it lies below the period exponent.
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign low_mask[g] = (32'(g) < shift_amt);
    end

endmodule

// File: rtl/per_irq_gen.sv
module per_irq_gen
    import pig_pkg::*;
#(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned CNT_W    = 15,
    parameter int unsigned FLAG_W   = 8,
    parameter logic [7:0]  FLAG_VAL = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              reprog,
    output logic              flag_set,
    output logic [FLAG_W-1:0] flag_mask
);

    logic [CODE_W-1:0] cfg_code;
    logic              cfg_pie;
    logic [CODE_W-1:0] eff_code;
    logic              eff_pie;
    logic              code_on;
    logic              gen_on;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  low_mask;
    logic              boundary;
    logic              fire;

    pig_state_e state_q, state_d;

    // Stored configuration, refreshed on every control write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_code <= '0;
            cfg_pie  <= 1'b0;
        end else if (reprog) begin
            cfg_code <= rate_code;
            cfg_pie  <= pie_en;
        end
    end

    // A write in this cycle already governs this cycle's tick.
    assign eff_code = reprog ? rate_code : cfg_code;
    assign eff_pie  = reprog ? pie_en    : cfg_pie;

    pig_tick_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt     (cnt),
        .cnt_next(cnt_next)
    );

    pig_rate_decode #(
        .CODE_W(CODE_W),
        .CNT_W (CNT_W)
    ) i_dec (
        .code    (eff_code),
        .code_on (code_on),
        .low_mask(low_mask)
    );

    assign gen_on   = code_on && eff_pie;
    assign boundary = ((cnt_next & low_mask) == '0);
    assign fire     = tick_en && gen_on && boundary;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (fire)        state_d = ST_FIRE;
                else if (gen_on) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (fire)         state_d = ST_FIRE;
                else if (!gen_on) state_d = ST_OFF;
            end
            ST_FIRE: begin
                if (fire)        state_d = ST_FIRE;
                else if (gen_on) state_d = ST_WAIT;
                else             state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        flag_set  = (state_q == ST_FIRE);
        flag_mask = flag_set ? FLAG_W'(FLAG_VAL) : '0;
    end

    // R7: a pulse lasts a single cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> !flag_set);

    // R7: a pulse always follows an edge that took a tick.
    p_pulse_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |-> $past(tick_en));

    // R6: a pulse sits on a period multiple of the running count.
    p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |-> ((cnt & $past(low_mask)) == '0));

    // R3: writing a cleared enable silences the next cycle.
    p_pie_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reprog && !pie_en) |=> !flag_set);

    // R2: writing code 0 silences the next cycle.
    p_code0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reprog && (rate_code == '0)) |=> !flag_set);

endmodule

// File: tb/test_per_irq_gen.sv
module test_per_irq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       reprog = 1'b0;
    logic       flag_set;
    logic [7:0] flag_mask;

    int n_cmp = 0;
    int n_fail = 0;

    bit    q_exp[$];
    string q_tag[$];

    // Independent reference state.
    logic [14:0] mcnt = '0;
    logic [3:0]  mcode = '0;
    bit          mpie = 1'b0;

    always #4 clk = ~clk;

    per_irq_gen i_per_irq_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rate_code(rate_code),
        .pie_en   (pie_en),
        .reprog   (reprog),
        .flag_set (flag_set),
        .flag_mask(flag_mask)
    );

    function automatic bit predict(bit t, bit rp, logic [3:0] c, bit p);
        logic [3:0]  ec;
        bit          ep;
        int unsigned k;
        int unsigned period;
        logic [14:0] nxt;
        ec = rp ? c : mcode;
        ep = rp ? p : mpie;
        if (!t || !ep || ec == 0) return 1'b0;
        k = (ec <= 2) ? int'(ec) + 7 : int'(ec);
        period = 1 << (k - 1);
        nxt = mcnt + 15'd1;
        return ((int'(nxt) % period) == 0);
    endfunction

    task automatic step(input bit t, input bit rp, input logic [3:0] c,
                        input bit p, input string tag);
        bit e;
        @(negedge clk);
        tick_en   = t;
        reprog    = rp;
        rate_code = c;
        pie_en    = p;
        e = predict(t, rp, c, p);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        if (rp) begin
            mcode = c;
            mpie  = p;
        end
        if (t) mcnt = mcnt + 15'd1;
    endtask

    task automatic ticks(input int n, input logic [3:0] c, input bit p,
                         input bit sparse, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, c, p, tag);
            if (sparse) step(1'b0, 1'b0, c, p, tag);
        end
    endtask

    // Monitor: compares one scoreboard item per cycle, 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                bit          e;
                string       tg;
                logic [7:0]  em;
                e  = q_exp.pop_front();
                tg = q_tag.pop_front();
                em = e ? 8'hC0 : 8'h00;
                n_cmp++;
                if (flag_set !== e || flag_mask !== em) begin
                    n_fail++;
                    $display("FAIL %s: flag_set=%0b mask=%02h expected flag_set=%0b mask=%02h (tick count %0d)",
                             tg, flag_set, flag_mask, e, em, mcnt);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (flag_set !== 1'b0 || flag_mask !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: flag_set=%0b mask=%02h expected 0/00", flag_set, flag_mask);
        end
        rst_n = 1'b1;

        // R1: stored config starts disabled even with inputs asking for code 3
        ticks(12, 4'd3, 1'b1, 1'b0, "R1");

        // R2: code 0 with enable set
        step(1'b0, 1'b1, 4'd0, 1'b1, "R2");
        ticks(40, 4'd0, 1'b1, 1'b0, "R2");

        // R3: enable clear with a live code
        step(1'b0, 1'b1, 4'd3, 1'b0, "R3");
        ticks(40, 4'd3, 1'b0, 1'b0, "R3");

        // R4 / R7: several codes, dense and sparse ticks
        step(1'b0, 1'b1, 4'd3, 1'b1, "R4");
        ticks(40, 4'd3, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 4'd5, 1'b1, "R4");
        ticks(70, 4'd5, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 4'd7, 1'b1, "R4");
        ticks(200, 4'd7, 1'b1, 1'b1, "R4");

        // R5: aliased codes
        step(1'b0, 1'b1, 4'd1, 1'b1, "R5");
        ticks(300, 4'd1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 4'd2, 1'b1, "R5");
        ticks(600, 4'd2, 1'b1, 1'b0, "R5");

        // R9: inputs change without a strobe
        ticks(300, 4'd3, 1'b0, 1'b0, "R9");
        ticks(300, 4'd0, 1'b1, 1'b0, "R9");

        // R8: enable lands on the boundary tick itself
        step(1'b0, 1'b1, 4'd3, 1'b0, "R8");
        while (((mcnt + 15'd1) & 15'd3) != 15'd0)
            step(1'b1, 1'b0, 4'd3, 1'b0, "R8");
        step(1'b1, 1'b1, 4'd3, 1'b1, "R8");
        ticks(10, 4'd3, 1'b1, 1'b0, "R8");
        // R8: disable lands on the boundary tick itself
        while (((mcnt + 15'd1) & 15'd3) != 15'd0)
            step(1'b1, 1'b0, 4'd3, 1'b1, "R8");
        step(1'b1, 1'b1, 4'd3, 1'b0, "R8");
        ticks(10, 4'd3, 1'b0, 1'b0, "R8");

        // R6: slowest code across the 15-bit wrap
        step(1'b0, 1'b1, 4'd15, 1'b1, "R6");
        ticks(33000, 4'd15, 1'b1, 1'b0, "R6");

        step(1'b0, 1'b0, 4'd15, 1'b1, "R6");
        repeat (4) @(posedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule